// File: doc/BRIEF.md
# Synthesizer Serial Programming Sequencer

This block is the master side of a three-wire serial link (serial clock, serial data, latch enable) that loads a frequency-synthesizer device. A single-cycle start request captures four 24-bit configuration words from a parallel interface. The block then shifts them out most significant bit first, in a fixed order: initialization word, function word, reference-divider word, then feedback-divider word. After each word it pulses latch enable so that the device transfers the shifted bits into the latch they address. No counter-reset step sits between the words.

The serial clock runs at the system clock divided by `DIV`. Every bit period is cut into four equal phases: data update, clock rise, hold, clock fall. The data line therefore changes a quarter period away from both clock edges. Latch enable comes straight from a flip-flop, so it cannot glitch. It rises a programmable number of system cycles after the last falling clock edge of a word.

While the sequence runs, the block drives the shared lines and raises a bus-enable output. When the sequence ends, it drops all three lines low, drops the enable so that the pins can be tristated for other devices on the bus, and pulses done for one cycle.

Top module: `ssp_synth_loader`

## Requirements
- R1: One accepted start sends exactly four words, in this order: init, function, reference, feedback. The block overwrites the two least significant bits of each word with its latch code: init 2'b11, function 2'b10, reference 2'b00, feedback 2'b01. Bits [23:2] come from the matching input.
- R2: Each word is 24 bits long, sent most significant bit first. The value on the data line is valid at every rising edge of the serial clock.
- R3: The data line never changes in the same system cycle as a serial-clock edge. At least `DIV/4` system cycles separate a data change from the nearest clock edge.
- R4: Latch enable rises exactly `LE_GAP` system cycles after the last falling serial-clock edge of a word. The serial clock is low whenever latch enable is high.
- R5: Latch enable stays high for exactly `LE_HOLD` system cycles (`LE_HOLD >= DIV`). No serial-clock rise occurs while latch enable is high.
- R6: The bus enable is high from the cycle after start is accepted until the sequence ends, and busy tracks it. While the enable is low, clock, data and latch enable are all low.
- R7: A start request made while busy is ignored. The words are sampled only when start is accepted, so input changes during a sequence have no effect.
- R8: Done is high for exactly one cycle at the end of a sequence, in the first cycle in which busy is low.
- R9: After reset, busy, done, bus enable, serial clock, data and latch enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| init_word_i | input | 24 | Initialization word (bits [1:0] replaced) |
| func_word_i | input | 24 | Function word (bits [1:0] replaced) |
| ref_word_i | input | 24 | Reference-divider word (bits [1:0] replaced) |
| ncnt_word_i | input | 24 | Feedback-divider word (bits [1:0] replaced) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| bus_oe_o | output | 1 | Drive enable for the three shared lines |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| le_o | output | 1 | Latch enable for this device |

## Verification
The bench decodes the line with a shift-register receiver that samples at each rising clock edge. It measures the distance between every data change and every clock edge, so a data update moved onto an edge, or a phase counter off by one, shows up as a short separation. It times the gap from the final falling edge to latch enable and the width of the latch pulse, which catches a latch that fires early or a next word that starts too soon. It also sends words with wrong latch codes, re-issues start and changes the inputs mid-sequence, and checks the lines after release. A design that forgot the code overwrite, re-sampled its inputs, restarted, or left a line high while the bus was released would fail these checks.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int unsigned N_WORDS = 4;
  localparam int unsigned CODE_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_GAP   = 3'd3,
    ST_LATCH = 3'd4
  } seq_state_t;

  // Latch select code appended to each slot: slot order is init, function, reference, feedback.
  function automatic logic [CODE_W-1:0] slot_code(input int unsigned slot);
    case (slot)
      0:       slot_code = 2'b11;
      1:       slot_code = 2'b10;
      2:       slot_code = 2'b00;
      default: slot_code = 2'b01;
    endcase
  endfunction

  // Phase positions inside one bit period of div system cycles.
  function automatic int unsigned rise_phase(input int unsigned div);
    rise_phase = div / 4;
  endfunction

  function automatic int unsigned fall_phase(input int unsigned div);
    fall_phase = (3 * div) / 4;
  endfunction

endpackage

// File: rtl/ssp_phase_timer.sv
module ssp_phase_timer #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ph_data,
  output logic ph_rise,
  output logic ph_fall
);
  import ssp_pkg::*;

  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
  localparam logic [CW-1:0] RISE  = CW'(rise_phase(DIV));
  localparam logic [CW-1:0] FALL  = CW'(fall_phase(DIV));

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  assign ph_data = run && (cnt_q == '0);
  assign ph_rise = run && (cnt_q == RISE);
  assign ph_fall = run && (cnt_q == FALL);

  // R3: at most one phase event per cycle
  p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_data, ph_rise, ph_fall}));

endmodule

// File: rtl/ssp_shift_out.sv
module ssp_shift_out #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              ph_data,
  input  logic              ph_rise,
  input  logic              ph_fall,
  input  logic              clr,
  output logic              sclk,
  output logic              sdata
);

  logic [WORD_W-1:0] sreg_q;
  logic              sclk_q;
  logic              sdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
    end else if (clr) begin
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
    end else begin
      if (load) begin
        sreg_q <= load_word;
      end else if (ph_data) begin
        sdata_q <= sreg_q[WORD_W-1];
        sreg_q  <= {sreg_q[WORD_W-2:0], 1'b0};
      end
      if (ph_rise) sclk_q <= 1'b1;
      if (ph_fall) sclk_q <= 1'b0;
    end
  end

  assign sclk  = sclk_q;
  assign sdata = sdata_q;

  // R2: a rising edge is only requested while the clock is low
  p_rise_from_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_rise |-> !sclk_q);

  // R3: a data update is only requested while the clock is low
  p_update_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_data |-> !sclk_q);

endmodule

// File: rtl/ssp_seq_ctrl.sv
module ssp_seq_ctrl #(
  parameter int unsigned WORD_W  = 24,
  parameter int unsigned LE_GAP  = 3,
  parameter int unsigned LE_HOLD = 10
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start_i,
  input  logic [ssp_pkg::N_WORDS-1:0][WORD_W-1:0] words_i,
  input  logic                                   ph_fall,
  output logic                                   run,
  output logic                                   load,
  output logic [WORD_W-1:0]                      load_word,
  output logic                                   seq_end,
  output logic                                   le,
  output logic                                   busy,
  output logic                                   done,
  output logic                                   oe
);
  import ssp_pkg::*;

  localparam int unsigned BW    = $clog2(WORD_W);
  localparam int unsigned WMAX  = (LE_GAP > LE_HOLD) ? LE_GAP : LE_HOLD;
  localparam int unsigned WW    = $clog2(WMAX + 1);
  localparam int unsigned IW    = $clog2(N_WORDS);

  seq_state_t                       state_q;
  logic [N_WORDS-1:0][WORD_W-1:0]   cap_q;
  logic [IW-1:0]                    widx_q;
  logic [BW-1:0]                    bitcnt_q;
  logic [WW-1:0]                    wcnt_q;
  logic                             le_q, busy_q, done_q, oe_q;

  logic start_ok;
  logic word_last_fall;
  logic gap_end;
  logic hold_end;
  logic last_word;

  assign start_ok       = (state_q == ST_IDLE) && start_i;
  assign word_last_fall = (state_q == ST_SHIFT) && ph_fall && (bitcnt_q == BW'(WORD_W - 1));
  assign gap_end        = (state_q == ST_GAP)   && (wcnt_q == WW'(LE_GAP - 1));
  assign hold_end       = (state_q == ST_LATCH) && (wcnt_q == WW'(LE_HOLD - 1));
  assign last_word      = (widx_q == IW'(N_WORDS - 1));
  assign seq_end        = hold_end && last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cap_q    <= '0;
      widx_q   <= '0;
      bitcnt_q <= '0;
      wcnt_q   <= '0;
      le_q     <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          for (int k = 0; k < N_WORDS; k++)
            cap_q[k] <= {words_i[k][WORD_W-1:CODE_W], slot_code(k)};
          widx_q  <= '0;
          busy_q  <= 1'b1;
          oe_q    <= 1'b1;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          bitcnt_q <= '0;
          state_q  <= ST_SHIFT;
        end
        ST_SHIFT: if (ph_fall) begin
          if (word_last_fall) begin
            wcnt_q  <= '0;
            state_q <= ST_GAP;
          end else begin
            bitcnt_q <= bitcnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_end) begin
            le_q    <= 1'b1;
            wcnt_q  <= '0;
            state_q <= ST_LATCH;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        ST_LATCH: begin
          if (hold_end) begin
            le_q   <= 1'b0;
            wcnt_q <= '0;
            if (last_word) begin
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              oe_q    <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              widx_q  <= widx_q + 1'b1;
              state_q <= ST_LOAD;
            end
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run       = (state_q == ST_SHIFT);
  assign load      = (state_q == ST_LOAD);
  assign load_word = cap_q[widx_q];
  assign le        = le_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign oe        = oe_q;

  // R7: captured words stay frozen for as long as a sequence is running
  p_words_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || $stable(cap_q)));

  // R4: latch enable only rises after the gap that follows the final bit
  p_le_after_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le_q) |-> ($past(state_q) == ST_GAP));

  // R5: a new word is loaded only once latch enable is low
  p_load_le_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !le_q);

endmodule

// File: rtl/ssp_synth_loader.sv
module ssp_synth_loader #(
  parameter int unsigned WORD_W  = 24,
  parameter int unsigned DIV     = 8,
  parameter int unsigned LE_GAP  = 3,
  parameter int unsigned LE_HOLD = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] init_word_i,
  input  logic [WORD_W-1:0] func_word_i,
  input  logic [WORD_W-1:0] ref_word_i,
  input  logic [WORD_W-1:0] ncnt_word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              bus_oe_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              le_o
);
  import ssp_pkg::*;

  logic [N_WORDS-1:0][WORD_W-1:0] words;
  logic                           run, load, seq_end;
  logic                           ph_data, ph_rise, ph_fall;
  logic [WORD_W-1:0]              load_word;

  assign words[0] = init_word_i;
  assign words[1] = func_word_i;
  assign words[2] = ref_word_i;
  assign words[3] = ncnt_word_i;

  ssp_phase_timer #(.DIV(DIV)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .ph_data (ph_data),
    .ph_rise (ph_rise),
    .ph_fall (ph_fall)
  );

  ssp_seq_ctrl #(
    .WORD_W  (WORD_W),
    .LE_GAP  (LE_GAP),
    .LE_HOLD (LE_HOLD)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .words_i   (words),
    .ph_fall   (ph_fall),
    .run       (run),
    .load      (load),
    .load_word (load_word),
    .seq_end   (seq_end),
    .le        (le_o),
    .busy      (busy_o),
    .done      (done_o),
    .oe        (bus_oe_o)
  );

  ssp_shift_out #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (load_word),
    .ph_data   (ph_data),
    .ph_rise   (ph_rise),
    .ph_fall   (ph_fall),
    .clr       (seq_end),
    .sclk      (sclk_o),
    .sdata     (sdata_o)
  );

  // R3: data and serial clock never move in the same cycle
  p_data_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $stable(sclk_o));

  // R4: serial clock is low while latch enable is high
  p_le_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    le_o |-> !sclk_o);

  // R6: released bus carries all-low lines
  p_release_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> (!sclk_o && !sdata_o && !le_o));

  // R6: bus enable follows busy
  p_busy_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> bus_oe_o);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: done coincides with the first idle cycle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/tb_ssp_synth_loader.sv
module tb_ssp_synth_loader;

  localparam int unsigned W       = 24;
  localparam int unsigned DIV     = 8;
  localparam int unsigned GAP     = 3;
  localparam int unsigned HOLD    = 10;
  localparam int          MIN_SEP = DIV / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] w_init = '0, w_func = '0, w_ref = '0, w_ncnt = '0;
  logic busy_o, done_o, bus_oe_o, sclk_o, sdata_o, le_o;

  always #10 clk = ~clk;

  ssp_synth_loader #(.WORD_W(W), .DIV(DIV), .LE_GAP(GAP), .LE_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .init_word_i(w_init), .func_word_i(w_func), .ref_word_i(w_ref), .ncnt_word_i(w_ncnt),
    .busy_o(busy_o), .done_o(done_o), .bus_oe_o(bus_oe_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .le_o(le_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // receiving-device model
  logic [W-1:0] rx = '0;
  logic [W-1:0] got [8];
  int gotbits [8];
  int nbits = 0, nwords = 0, done_cnt = 0;
  int cyc = 0, last_e = -1000, last_d = -1000, le_start = 0;
  logic p_sclk = 0, p_sdata = 0, p_le = 0, p_busy = 0, p_done = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sclk_o !== p_sclk) begin
        chk(cyc - last_d >= MIN_SEP, "R3 clock edge near data change", cyc - last_d, MIN_SEP);
        last_e = cyc;
        if (sclk_o) begin
          rx = {rx[W-2:0], sdata_o};
          nbits++;
          chk(!le_o && bus_oe_o, "R5 rise with latch low and bus driven", {le_o, bus_oe_o}, 2'b01);
        end
      end
      if (sdata_o !== p_sdata && bus_oe_o) begin
        chk(cyc - last_e >= MIN_SEP, "R3 data change near clock edge", cyc - last_e, MIN_SEP);
        last_d = cyc;
      end
      if (le_o && !p_le) begin
        chk(cyc - last_e == GAP, "R4 latch delay after last fall", cyc - last_e, GAP);
        chk(!sclk_o && bus_oe_o, "R4 clock low at latch", {sclk_o, bus_oe_o}, 2'b01);
        if (nwords < 8) begin
          got[nwords] = rx;
          gotbits[nwords] = nbits;
        end
        nwords++;
        nbits = 0;
        le_start = cyc;
      end
      if (!le_o && p_le)
        chk(cyc - le_start == HOLD, "R5 latch width", cyc - le_start, HOLD);
      if (done_o) begin
        done_cnt++;
        chk(!busy_o && p_busy, "R8 done at first idle cycle", {busy_o, p_busy}, 2'b01);
        chk(!p_done, "R8 done single cycle", p_done, 0);
      end
    end
    p_sclk = sclk_o; p_sdata = sdata_o; p_le = le_o; p_busy = busy_o; p_done = done_o;
  end

  function automatic logic [W-1:0] expect_word(input logic [W-1:0] w, input int slot);
    logic [1:0] tab [4];
    tab = '{2'b11, 2'b10, 2'b00, 2'b01};
    return {w[W-1:2], tab[slot]};
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && done_cnt == 0; i++) @(negedge clk);
    chk(done_cnt != 0, "R8 sequence completes", done_cnt, 1);
  endtask

  task automatic check_words(input logic [W-1:0] a, b, c, d, input string name);
    logic [W-1:0] in [4];
    in = '{a, b, c, d};
    chk(nwords == 4, {"R1 word count ", name}, nwords, 4);
    for (int k = 0; k < 4; k++) begin
      chk(gotbits[k] == W, {"R2 bits per word ", name}, gotbits[k], W);
      chk(got[k] == expect_word(in[k], k), {"R1 R2 word value ", name}, got[k], expect_word(in[k], k));
    end
  endtask

  task automatic check_release(input string name);
    repeat (20) @(negedge clk);
    chk(!bus_oe_o && !busy_o, {"R6 bus released ", name}, {bus_oe_o, busy_o}, 0);
    chk(!sclk_o && !sdata_o && !le_o, {"R6 lines low ", name}, {sclk_o, sdata_o, le_o}, 0);
    chk(done_cnt == 1, {"R8 one done ", name}, done_cnt, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({busy_o, done_o, bus_oe_o, sclk_o, sdata_o, le_o} == 6'b0, "R9 reset outputs",
        {busy_o, done_o, bus_oe_o, sclk_o, sdata_o, le_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_oe_o && !busy_o, "R9 idle after reset", {bus_oe_o, busy_o}, 0);
  endtask

  task automatic t_sequence(input logic [W-1:0] a, b, c, d, input string name);
    w_init = a; w_func = b; w_ref = c; w_ncnt = d;
    nwords = 0; done_cnt = 0; nbits = 0;
    pulse_start();
    chk(bus_oe_o && busy_o, {"R6 bus driven after start ", name}, {bus_oe_o, busy_o}, 2'b11);
    wait_done();
    check_words(a, b, c, d, name);
    check_release(name);
  endtask

  task automatic t_busy_start();
    logic [W-1:0] a, b, c, d;
    a = 24'h5A5A5A; b = 24'hC3C3C0; c = 24'h00F00F; d = 24'h123457;
    w_init = a; w_func = b; w_ref = c; w_ncnt = d;
    nwords = 0; done_cnt = 0; nbits = 0;
    pulse_start();
    repeat (100) @(negedge clk);
    w_init = ~a; w_func = ~b; w_ref = ~c; w_ncnt = ~d;
    pulse_start();
    chk(busy_o, "R7 still busy after second start", busy_o, 1);
    wait_done();
    check_words(a, b, c, d, "busy-restart");
    repeat (1500) @(negedge clk);
    chk(nwords == 4, "R7 no second sequence", nwords, 4);
    chk(done_cnt == 1 && !bus_oe_o, "R7 no extra done", done_cnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequence(24'h123456, 24'hABCDEF, 24'h000001, 24'h800002, "mixed");
    t_sequence(24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, "ones");
    t_sequence(24'hAAAAAA, 24'h555555, 24'hAAAAAA, 24'h555555, "alternating");
    t_sequence(24'h000000, 24'h000000, 24'h000000, 24'h000000, "zeros");
    t_busy_start();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule